// File: doc/BRIEF.md
# Three-Wire Digital Potentiometer Command Sequencer

This block sits on the host side of a digital up/down potentiometer that is driven by three pins: an active-low select, a direction level and an active-low step strobe. The device moves its wiper one tap on each falling edge of the strobe while it is selected. When the select is released, the strobe level at that moment decides one of two things. A high strobe makes the device commit the position to nonvolatile memory. A low strobe leaves the stored position alone. The sequencer takes one command at a time through a valid/ready handshake and turns it into pin waveforms that meet every setup, pulse-width and deselect time of the device.

A command carries three fields: a direction bit, a step count from 0 to 31 and a store flag. All timing limits are parameters in nanoseconds. Each one is rounded up to whole clock cycles of the given clock period, with a floor of one cycle. The block raises a one-cycle done pulse when the full sequence is over, including the deselect hold-off that belongs to the chosen ending. It then accepts the next command.

Top module: `pot3w_seq`

## Requirements
- R1: During and after reset, select and strobe are high, ready is high and done is low. In idle, select and strobe are both high.
- R2: Ready is high only in idle. A command is taken on a clock edge where valid and ready are both high. Ready stays low from the next cycle until the cycle in which done is high.
- R3: For a command that selects the device, select falls and the direction pin takes the command's direction bit (1 = toward the high end, wiper count rising) on the cycle after acceptance. The first strobe falling edge follows exactly C_SETUP cycles later. C_SETUP is the largest of the rounded select setup, direction setup and strobe high time.
- R4: Exactly N strobe falling edges are issued, all while select is low. The strobe is never driven low while select is high. Each strobe low phase that ends in a rising edge lasts C_LOW cycles. Each high phase between two falling edges lasts C_HIGH cycles.
- R5: The direction pin does not change while select is low.
- R6: With the store flag set and N > 0, select rises with the strobe high, C_TAIL_HI = max(C_HIGH, rounded tail time) cycles after the last strobe rising edge. Select then stays high for C_STORE cycles before done.
- R7: With the store flag clear and N > 0, the last strobe low phase is held, and select rises with the strobe still low, C_TAIL_LO = max(C_LOW, rounded tail time) cycles after the last falling edge. The strobe returns high C_SKIP cycles later. It then stays high for C_REARM cycles (the rounded direction hold) before done.
- R8: With N = 0 and the store flag set, the device is selected for C_SETUP cycles and released with the strobe high. With N = 0 and the store flag clear, select never falls and done follows after C_REARM cycles.
- R9: Done is high for exactly one cycle. Counted from the acceptance edge, it rises after C_SETUP + (N-1)(C_LOW+C_HIGH) + C_LOW + C_TAIL_HI + C_STORE cycles for a store, and after C_SETUP + (N-1)(C_LOW+C_HIGH) + C_TAIL_LO + C_SKIP + C_REARM cycles for a skip. The zero-step cases take C_SETUP + C_STORE and C_REARM.
- R10: Every cycle count is the nanosecond parameter divided by the clock period, rounded up, and at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Sequencer idle and able to take a command |
| cmd_up_i | input | 1 | Direction: 1 moves the wiper toward the high end |
| cmd_steps_i | input | STEP_W | Number of strobe pulses, 0 to 2^STEP_W-1 |
| cmd_store_i | input | 1 | 1 commits the position to memory on release |
| done_o | output | 1 | One-cycle pulse when the sequence and its hold-off are over |
| pot_sel_n_o | output | 1 | Active-low device select |
| pot_dir_o | output | 1 | Direction level to the device |
| pot_step_n_o | output | 1 | Active-low step strobe |

## Verification
Every pin transition occurs on a clock edge that can be predicted from the acceptance edge. Select and direction change on that edge. The first strobe fall comes C_SETUP cycles later. Each later edge is spaced by the rounded low, high or tail count, and done appears exactly at the R9 latency. The bench samples all pins on falling clock edges and timestamps each transition in cycles. It compares the gaps with counts it derives from the nanosecond parameters by its own ceiling division. A bench model of the device tracks the tap and the stored tap, and the bench checks both against arithmetic saturation. The bench sweeps every step count with both directions and both store settings on a shortened timing configuration.

// File: rtl/potseq_pkg.sv
package potseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD_ST,
    ST_HOLD_SK,
    ST_REARM
  } seq_state_t;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int unsigned ns_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/potseq_timer.sv
module potseq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R10
  tmr_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/potseq_steps.sv
module potseq_steps #(
  parameter int unsigned SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [SW-1:0] val_i,
  input  logic          dec_i,
  output logic          last_o,
  output logic          empty_o
);

  logic [SW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (load_i) begin
      left_d = val_i;
    end else if (dec_i) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else begin
      left_q <= left_d;
    end
  end

  assign last_o  = (left_q == SW'(1));
  assign empty_o = (left_q == '0);

  // R4
  step_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> !empty_o);

endmodule

// File: rtl/potseq_pins.sv
module potseq_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_d,
  input  logic step_n_d,
  input  logic dir_en,
  input  logic dir_d,
  output logic sel_n_q,
  output logic step_n_q,
  output logic dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n_q  <= 1'b1;
      step_n_q <= 1'b1;
    end else begin
      sel_n_q  <= sel_n_d;
      step_n_q <= step_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/pot3w_seq.sv
module pot3w_seq
  import potseq_pkg::*;
#(
  parameter int unsigned STEP_W          = 5,
  parameter int unsigned CLK_NS          = 4,
  parameter int unsigned T_SEL_SETUP_NS  = 100,
  parameter int unsigned T_DIR_SETUP_NS  = 2900,
  parameter int unsigned T_DIR_HOLD_NS   = 100,
  parameter int unsigned T_LOW_NS        = 1000,
  parameter int unsigned T_HIGH_NS       = 1000,
  parameter int unsigned T_TAIL_NS       = 1000,
  parameter int unsigned T_STORE_NS      = 20000000,
  parameter int unsigned T_SKIP_NS       = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_up_i,
  input  logic [STEP_W-1:0] cmd_steps_i,
  input  logic              cmd_store_i,
  output logic              done_o,
  output logic              pot_sel_n_o,
  output logic              pot_dir_o,
  output logic              pot_step_n_o
);

  localparam int unsigned C_LOW     = ns_cyc(T_LOW_NS, CLK_NS);
  localparam int unsigned C_HIGH    = ns_cyc(T_HIGH_NS, CLK_NS);
  localparam int unsigned C_TAIL    = ns_cyc(T_TAIL_NS, CLK_NS);
  localparam int unsigned C_SETUP   = umax(umax(ns_cyc(T_SEL_SETUP_NS, CLK_NS),
                                                ns_cyc(T_DIR_SETUP_NS, CLK_NS)), C_HIGH);
  localparam int unsigned C_TAIL_HI = umax(C_HIGH, C_TAIL);
  localparam int unsigned C_TAIL_LO = umax(C_LOW, C_TAIL);
  localparam int unsigned C_STORE   = ns_cyc(T_STORE_NS, CLK_NS);
  localparam int unsigned C_SKIP    = ns_cyc(T_SKIP_NS, CLK_NS);
  localparam int unsigned C_REARM   = ns_cyc(T_DIR_HOLD_NS, CLK_NS);
  localparam int unsigned C_MAX     = umax(umax(umax(C_SETUP, C_TAIL_HI), umax(C_TAIL_LO, C_STORE)),
                                           umax(C_SKIP, C_REARM));
  localparam int unsigned TW        = $clog2(C_MAX + 1);

  localparam logic [TW-1:0] LD_SETUP   = TW'(C_SETUP - 1);
  localparam logic [TW-1:0] LD_LOW     = TW'(C_LOW - 1);
  localparam logic [TW-1:0] LD_HIGH    = TW'(C_HIGH - 1);
  localparam logic [TW-1:0] LD_TAIL_HI = TW'(C_TAIL_HI - 1);
  localparam logic [TW-1:0] LD_TAIL_LO = TW'(C_TAIL_LO - 1);
  localparam logic [TW-1:0] LD_STORE   = TW'(C_STORE - 1);
  localparam logic [TW-1:0] LD_SKIP    = TW'(C_SKIP - 1);
  localparam logic [TW-1:0] LD_REARM   = TW'(C_REARM - 1);

  seq_state_t    st_q, st_d;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          stp_load, stp_dec, stp_last, stp_empty;
  logic          store_q, store_d;
  logic          sel_d, inc_d, dir_en;
  logic          done_d, done_q;
  logic          accept;

  assign accept = (st_q == ST_IDLE) && cmd_valid_i;

  // Next-state and pin-level decisions.
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    stp_load = 1'b0;
    stp_dec  = 1'b0;
    sel_d    = pot_sel_n_o;
    inc_d    = pot_step_n_o;
    dir_en   = 1'b0;
    done_d   = 1'b0;
    store_d  = store_q;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          stp_load = 1'b1;
          dir_en   = 1'b1;
          store_d  = cmd_store_i;
          tmr_load = 1'b1;
          if ((cmd_steps_i != '0) || cmd_store_i) begin
            st_d    = ST_SETUP;
            tmr_val = LD_SETUP;
            sel_d   = 1'b0;
            inc_d   = 1'b1;
          end else begin
            st_d    = ST_REARM;
            tmr_val = LD_REARM;
          end
        end
      end
      ST_SETUP, ST_HIGH: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (stp_empty) begin
            st_d    = ST_HOLD_ST;
            tmr_val = LD_STORE;
            sel_d   = 1'b1;
          end else begin
            st_d    = ST_LOW;
            inc_d   = 1'b0;
            tmr_val = (stp_last && !store_q) ? LD_TAIL_LO : LD_LOW;
          end
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          stp_dec  = 1'b1;
          if (stp_last && !store_q) begin
            st_d    = ST_HOLD_SK;
            tmr_val = LD_SKIP;
            sel_d   = 1'b1;
          end else begin
            st_d    = ST_HIGH;
            inc_d   = 1'b1;
            tmr_val = stp_last ? LD_TAIL_HI : LD_HIGH;
          end
        end
      end
      ST_HOLD_SK: begin
        if (tmr_zero) begin
          st_d     = ST_REARM;
          tmr_load = 1'b1;
          tmr_val  = LD_REARM;
          inc_d    = 1'b1;
        end
      end
      ST_HOLD_ST, ST_REARM: begin
        if (tmr_zero) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        sel_d = 1'b1;
        inc_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      store_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      store_q <= store_d;
    end
  end

  potseq_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  potseq_steps #(.SW(STEP_W)) u_steps (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (stp_load),
    .val_i   (cmd_steps_i),
    .dec_i   (stp_dec),
    .last_o  (stp_last),
    .empty_o (stp_empty)
  );

  potseq_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n_d  (sel_d),
    .step_n_d (inc_d),
    .dir_en   (dir_en),
    .dir_d    (cmd_up_i),
    .sel_n_q  (pot_sel_n_o),
    .step_n_q (pot_step_n_o),
    .dir_q    (pot_dir_o)
  );

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign done_o      = done_q;

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> (pot_sel_n_o && pot_step_n_o));

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready_o);

  // R4
  step_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pot_step_n_o) |-> !pot_sel_n_o);

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pot_sel_n_o && $past(!pot_sel_n_o)) |-> $stable(pot_dir_o));

  // R6
  store_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pot_sel_n_o) && store_q) |-> pot_step_n_o);

  // R7
  skip_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pot_sel_n_o) && !store_q) |-> !pot_step_n_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/pot3w_seq_bench.sv
`timescale 1ns/1ps
module pot3w_seq_bench;

  localparam int CLK_NS = 4;
  localparam int P_SEL = 10, P_DIRS = 30, P_DIRH = 9, P_LOW = 20, P_HIGH = 14;
  localparam int P_TAIL = 26, P_STORE = 60, P_SKIP = 6;
  localparam int TAPS = 32;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R10: expected counts by ceiling division
  localparam int E_LOW     = cyc(P_LOW);
  localparam int E_HIGH    = cyc(P_HIGH);
  localparam int E_SETUP   = imax(imax(cyc(P_SEL), cyc(P_DIRS)), E_HIGH);
  localparam int E_TAIL_HI = imax(E_HIGH, cyc(P_TAIL));
  localparam int E_TAIL_LO = imax(E_LOW, cyc(P_TAIL));
  localparam int E_STORE   = cyc(P_STORE);
  localparam int E_SKIP    = cyc(P_SKIP);
  localparam int E_REARM   = cyc(P_DIRH);

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_up, cmd_store;
  logic [4:0] cmd_steps;
  logic cmd_ready, done, sel_n, dir, step_n;

  always #2 clk = ~clk;

  pot3w_seq #(
    .STEP_W(5), .CLK_NS(CLK_NS), .T_SEL_SETUP_NS(P_SEL), .T_DIR_SETUP_NS(P_DIRS),
    .T_DIR_HOLD_NS(P_DIRH), .T_LOW_NS(P_LOW), .T_HIGH_NS(P_HIGH), .T_TAIL_NS(P_TAIL),
    .T_STORE_NS(P_STORE), .T_SKIP_NS(P_SKIP)
  ) u_pot3w_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_up_i(cmd_up), .cmd_steps_i(cmd_steps), .cmd_store_i(cmd_store), .done_o(done),
    .pot_sel_n_o(sel_n), .pot_dir_o(dir), .pot_step_n_o(step_n)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Device model and edge timestamps, sampled on falling clock edges.
  int cyc_n, pos, stored;
  int falls, stray, cs_falls, cs_rises, rel_inc, dir_moves;
  int t_cs_fall, t_cs_rise, t_fall, t_rise, t_last;
  int first_gap, tail_gap, post_gap, lo_min, lo_max, hi_min, hi_max;
  bit seen_first, rise_in_sel;
  logic p_sel, p_inc, p_dir;

  task automatic clear_stats();
    falls = 0; stray = 0; cs_falls = 0; cs_rises = 0; rel_inc = -1; dir_moves = 0;
    first_gap = -1; tail_gap = -1; post_gap = -1;
    lo_min = 9999; lo_max = 0; hi_min = 9999; hi_max = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sel = 1'b1; p_inc = 1'b1; p_dir = dir;
      pos = 16; stored = 16; cyc_n = 0;
    end else begin
      cyc_n++;
      if (p_sel && !sel_n) begin
        cs_falls++; t_cs_fall = cyc_n; seen_first = 0; rise_in_sel = 0;
      end
      if (p_inc && !step_n) begin
        if (!sel_n) begin
          falls++;
          if (dir) pos = (pos < TAPS - 1) ? pos + 1 : pos;
          else     pos = (pos > 0) ? pos - 1 : pos;
          if (!seen_first) begin first_gap = cyc_n - t_cs_fall; seen_first = 1; end
          if (rise_in_sel) begin
            hi_min = (cyc_n - t_rise < hi_min) ? cyc_n - t_rise : hi_min;
            hi_max = (cyc_n - t_rise > hi_max) ? cyc_n - t_rise : hi_max;
          end
          t_last = cyc_n;
        end else stray++;
        t_fall = cyc_n;
      end
      if (!p_inc && step_n) begin
        if (!sel_n) begin
          lo_min = (cyc_n - t_fall < lo_min) ? cyc_n - t_fall : lo_min;
          lo_max = (cyc_n - t_fall > lo_max) ? cyc_n - t_fall : lo_max;
          t_last = cyc_n; rise_in_sel = 1;
        end else if (p_sel) begin
          post_gap = cyc_n - t_cs_rise;
        end
        t_rise = cyc_n;
      end
      if (!p_sel && sel_n) begin
        cs_rises++; rel_inc = step_n; tail_gap = cyc_n - t_last; t_cs_rise = cyc_n;
        if (step_n) stored = pos;
      end
      if (!sel_n && !p_sel && (dir != p_dir)) dir_moves++;
      p_sel = sel_n; p_inc = step_n; p_dir = dir;
    end
  end

  int exp_pos = 16, exp_store = 16;

  function automatic int exp_lat(input int n, input bit st);
    int body;
    if (n == 0) return st ? E_SETUP + E_STORE : E_REARM;
    body = E_SETUP + (n - 1) * (E_LOW + E_HIGH);
    return st ? body + E_LOW + E_TAIL_HI + E_STORE : body + E_TAIL_LO + E_SKIP + E_REARM;
  endfunction

  task automatic run_cmd(input int n, input bit up, input bit st);
    int idx, busy_rdy, lows, highs;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_up = up; cmd_steps = 5'(n); cmd_store = st;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    clear_stats();
    @(negedge clk);
    cmd_valid = 1'b0;
    idx = 0; busy_rdy = 0;
    while (!done && idx < 5000) begin
      if (cmd_ready) busy_rdy++;
      idx++;
      @(negedge clk);
    end
    // R9 R10 latency, R2 ready while busy
    check(idx == exp_lat(n, st), "R9 latency", idx, exp_lat(n, st));
    check(busy_rdy == 0, "R2 ready while busy", busy_rdy, 0);
    // R4 pulse count
    check(falls == n && stray == 0, "R4 strobe falls", falls + 100 * stray, n);
    if (n == 0 && !st) begin
      check(cs_falls == 0 && step_n == 1'b1, "R8 no selection", cs_falls, 0);
    end else begin
      check(cs_falls == 1 && cs_rises == 1, "R3 one selection", cs_falls * 10 + cs_rises, 11);
      check(rel_inc == int'(st), "R6 R7 strobe at release", rel_inc, int'(st));
      if (n > 0) begin
        check(first_gap == E_SETUP, "R3 setup gap", first_gap, E_SETUP);
        check(tail_gap == (st ? E_TAIL_HI : E_TAIL_LO), "R6 R7 tail gap", tail_gap,
              st ? E_TAIL_HI : E_TAIL_LO);
      end
      if (n > 0 && !st) check(post_gap == E_SKIP, "R7 skip hold", post_gap, E_SKIP);
    end
    lows = st ? n : n - 1;
    highs = n - 1;
    if (lows > 0) check(lo_min == E_LOW && lo_max == E_LOW, "R4 low width", lo_max, E_LOW);
    if (highs > 0) check(hi_min == E_HIGH && hi_max == E_HIGH, "R4 high width", hi_max, E_HIGH);
    check(dir_moves == 0 && dir == up, "R5 direction", dir_moves * 10 + int'(dir), int'(up));
    if (n > 0) exp_pos = up ? ((exp_pos + n > TAPS - 1) ? TAPS - 1 : exp_pos + n)
                            : ((exp_pos - n < 0) ? 0 : exp_pos - n);
    if (st) exp_store = exp_pos;
    check(pos == exp_pos, "R4 wiper tap", pos, exp_pos);
    check(stored == exp_store, "R6 stored tap", stored, exp_store);
    @(negedge clk);
    check(!done && cmd_ready, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_up = 1'b0; cmd_steps = '0; cmd_store = 1'b0;
    repeat (3) @(negedge clk);
    check(sel_n && step_n && cmd_ready && !done, "R1 in reset",
          {28'd0, sel_n, step_n, cmd_ready, done}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sel_n && step_n && cmd_ready && !done, "R1 after reset",
          {28'd0, sel_n, step_n, cmd_ready, done}, 4'b1110);
    for (int n = 0; n < 32; n++)
      for (int u = 0; u < 2; u++)
        for (int s = 0; s < 2; s++)
          run_cmd(n, u[0] ^ n[0], s[0]);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule